// File: doc/BRIEF.md
# Serial Audio Frame Master

This block is the clock master of a serial audio link that carries one ADC channel out and two DAC channels in. It runs on the master clock and divides it down to a bit clock at 32 times the sample rate and a frame clock at the sample rate. Each frame holds 32 bit slots. The frame clock is high for the first 16 slots, which form the left half, and low for the last 16, which form the right half.

During the high half, a 16-bit two's complement ADC sample is shifted out MSB first on the serial output. The output is held low for the whole low half. On the serial input, a left DAC word is received in the high half and a right DAC word in the low half. Both words are delivered together on parallel outputs with a one-cycle valid strobe.

A ratio select input chooses between 256 and 512 master clocks per frame. The select is only latched while all three power-down inputs are high. While all three are high, both clocks are held low and the frame logic is cleared, so the next frame starts from its first slot.

Top module: `serial_audio_master`

## Requirements
- R1: With the latched ratio at 1, the bit clock period is DIV_FAST (8) master clocks. With it at 0, the period is DIV_SLOW (16) master clocks. In both cases the clock is low for the first half of the period and high for the second.
- R2: A frame is exactly 32 bit-clock periods. The frame clock is high for the first 16 and low for the last 16. Each frame-clock transition falls together with a bit-clock falling edge, and the bit clock is low when a frame starts.
- R3: While the frame clock is high, the serial output carries the ADC word MSB first, one bit per bit-clock period. Bit 15 is in the first slot.
- R4: While the frame clock is low, the serial output is 0.
- R5: While running, the serial output changes only on a bit-clock falling edge or when a frame starts. A receiver can therefore capture it on the rising edge.
- R6: The serial input is sampled on each bit-clock rising edge. The first 16 samples of a frame, MSB first, form the left word and the last 16 form the right word. One master-clock cycle after the last right bit is sampled, both words appear on the parallel outputs and the valid strobe is high for exactly one cycle.
- R7: While all three power-down inputs are 1, the bit clock, frame clock and serial output are 0. While any of them is 0, the clocks run.
- R8: The ratio select is latched only while all three power-down inputs are 1. A change made while any section is powered up has no effect until the next full power-down. Reset selects ratio 1.
- R9: The parallel ADC word is captured when the frame clock rises. A change of that input later in the frame does not alter the word being sent.
- R10: Reset clears the valid strobe and the DAC outputs and holds all serial outputs low. After reset or a full power-down, the first frame starts with the frame clock rising and carries a complete ADC word. A frame cut short by reset or power-down produces no valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | 1 | 1: DIV_FAST clocks per bit (256 per frame), 0: DIV_SLOW (512 per frame) |
| pd_adc | input | 1 | ADC section power-down |
| pd_dac_l | input | 1 | Left DAC power-down |
| pd_dac_r | input | 1 | Right DAC power-down |
| sdin | input | 1 | Serial DAC data in |
| adc_word | input | WORD | Parallel ADC sample |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock, high for the left half |
| sdout | output | 1 | Serial ADC data out |
| dac_left | output | WORD | Received left DAC word |
| dac_right | output | WORD | Received right DAC word |
| dac_valid | output | 1 | One-cycle strobe on a new DAC pair |

## Verification
The bench builds the block with its default parameters: WORD 16, DIV_FAST 8 and DIV_SLOW 16. This gives both real master-clock ratios and full 16-bit words, so the extreme code values 0x8000, 0x7FFF and 0xFFFF travel across a complete frame. With 256 and 512 master clocks per frame, a ratio change made while running, a full power-down that switches the ratio, and frames cut off by power-down and by reset all fit in a few thousand cycles. Each of these is then compared against queued expected words.

// File: rtl/serial_audio_master.sv
module serial_audio_master #(
  parameter int WORD     = 16,
  parameter int DIV_FAST = 8,
  parameter int DIV_SLOW = 16
) (
  input  logic            mclk,
  input  logic            rst,
  input  logic            ratio_sel,
  input  logic            pd_adc,
  input  logic            pd_dac_l,
  input  logic            pd_dac_r,
  input  logic            sdin,
  input  logic [WORD-1:0] adc_word,
  output logic            bclk,
  output logic            fclk,
  output logic            sdout,
  output logic [WORD-1:0] dac_left,
  output logic [WORD-1:0] dac_right,
  output logic            dac_valid
);
  // WORD and both dividers are powers of two
  localparam int SLOTS = 2 * WORD;
  localparam int SW    = $clog2(SLOTS);
  localparam int MW    = $clog2(DIV_SLOW);

  logic             pd_all, run, ratio_q, slot_end, sample_pt, last_slot;
  logic [MW-1:0]    mc, mc_last, mc_mid;
  logic [SW-1:0]    slot;
  logic [WORD-1:0]  adc_hold;
  logic [SLOTS-1:0] dac_sr;

  assign pd_all    = pd_adc & pd_dac_l & pd_dac_r;
  assign run       = ~pd_all & ~rst;
  assign mc_last   = ratio_q ? MW'(DIV_FAST - 1) : MW'(DIV_SLOW - 1);
  assign mc_mid    = ratio_q ? MW'(DIV_FAST / 2 - 1) : MW'(DIV_SLOW / 2 - 1);
  assign slot_end  = (mc == mc_last);
  assign last_slot = (slot == SW'(SLOTS - 1));
  assign sample_pt = run && (mc == mc_mid);

  assign bclk  = run && (mc > mc_mid);
  assign fclk  = run && (slot < SW'(WORD));
  assign sdout = fclk && adc_hold[~slot[SW-2:0]];

  always_ff @(posedge mclk) begin
    if (rst) begin
      mc        <= '0;
      slot      <= '0;
      ratio_q   <= 1'b1;
      dac_valid <= 1'b0;
      dac_left  <= '0;
      dac_right <= '0;
    end else begin
      dac_valid <= 1'b0;
      if (pd_all) begin
        mc      <= '0;
        slot    <= '0;
        ratio_q <= ratio_sel;
      end else begin
        if (slot_end) begin
          mc   <= '0;
          slot <= slot + 1'b1;
        end else begin
          mc <= mc + 1'b1;
        end
        if (sample_pt) begin
          dac_sr <= {dac_sr[SLOTS-2:0], sdin};
          if (last_slot) begin
            dac_left  <= dac_sr[SLOTS-2:WORD-1];
            dac_right <= {dac_sr[WORD-2:0], sdin};
            dac_valid <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge mclk) begin
    if (!run || (slot_end && last_slot))
      adc_hold <= adc_word;
  end

endmodule

module serial_audio_master_chk (
  input logic mclk,
  input logic rst,
  input logic pd_adc,
  input logic pd_dac_l,
  input logic pd_dac_r,
  input logic bclk,
  input logic fclk,
  input logic sdout,
  input logic dac_valid,
  input logic ratio_q
);
  logic pd_all;
  assign pd_all = pd_adc & pd_dac_l & pd_dac_r;

  assert_frame_starts_low_R2: assert property (@(posedge mclk) disable iff (rst)
    $rose(fclk) |-> !bclk);

  assert_low_half_quiet_R4: assert property (@(posedge mclk) disable iff (rst)
    !fclk |-> !sdout);

  assert_change_on_fall_R5: assert property (@(posedge mclk) disable iff (rst || pd_all)
    !$stable(sdout) |-> ($fell(bclk) || $rose(fclk)));

  assert_valid_single_R6: assert property (@(posedge mclk) disable iff (rst)
    dac_valid |=> !dac_valid);

  assert_clocks_parked_R7: assert property (@(posedge mclk) disable iff (rst)
    pd_all |-> (!bclk && !fclk && !sdout));

  assert_ratio_frozen_R8: assert property (@(posedge mclk) disable iff (rst)
    (!pd_all && !$past(pd_all) && !$past(rst)) |-> $stable(ratio_q));
endmodule

bind serial_audio_master serial_audio_master_chk u_chk (
  .mclk(mclk), .rst(rst), .pd_adc(pd_adc), .pd_dac_l(pd_dac_l),
  .pd_dac_r(pd_dac_r), .bclk(bclk), .fclk(fclk), .sdout(sdout),
  .dac_valid(dac_valid), .ratio_q(ratio_q)
);

// File: tb/sim_serial_audio_master.sv
module sim_serial_audio_master;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, ratio_sel = 1'b1, sdin = 1'b0;
  logic        pd_adc = 1'b1, pd_dac_l = 1'b1, pd_dac_r = 1'b1;
  logic [15:0] adc_word = 16'h8000;
  logic        bclk, fclk, sdout, dac_valid;
  logic [15:0] dac_left, dac_right;

  serial_audio_master u0 (
    .mclk(clk), .rst(rst), .ratio_sel(ratio_sel), .pd_adc(pd_adc),
    .pd_dac_l(pd_dac_l), .pd_dac_r(pd_dac_r), .sdin(sdin), .adc_word(adc_word),
    .bclk(bclk), .fclk(fclk), .sdout(sdout), .dac_left(dac_left),
    .dac_right(dac_right), .dac_valid(dac_valid)
  );

  int checks = 0, errors = 0, adc_done = 0, dac_done = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [15:0] adc_q[$];
  logic [31:0] dac_pending[$];
  logic [31:0] dac_exp[$];

  task automatic push_dac(input logic [15:0] l, input logic [15:0] r);
    dac_pending.push_back({l, r});
  endtask

  // monitor and serial driver, away from the active edge
  logic        prev_b = 0, prev_l = 0, prev_s = 0, eff_ratio = 1, cur_restart = 0;
  logic [15:0] prev_adc = 0, acc = 0;
  logic [31:0] cur_frame = 0;
  int          since_rise = 0, bitpos = 0, slot_i = 0;
  bit          have_rise = 0, frame_full = 0, was_idle = 1;

  always @(negedge clk) begin
    logic idle, rose, fell, brise;
    idle  = rst || (pd_adc && pd_dac_l && pd_dac_r);
    rose  = fclk && !prev_l;
    fell  = !bclk && prev_b;
    brise = bclk && !prev_b;
    if (rst) eff_ratio = 1'b1;
    else if (pd_adc && pd_dac_l && pd_dac_r) eff_ratio = ratio_sel;
    since_rise++;
    if (idle) begin
      have_rise = 0; frame_full = 0; was_idle = 1;
      if (!rst) check(!bclk && !fclk && !sdout, "R7", "parked outputs",
                      {bclk, fclk, sdout}, 0);
    end else if (sdout !== prev_s) begin
      check(fell || rose, "R5", "sdout moved off falling edge", {prev_b, bclk}, 2'b10);
    end
    if (rose) begin
      if (frame_full) check(bitpos == 32, "R2", "bit clocks per frame", bitpos, 32);
      check(!bclk, "R2", "bclk at frame start", bclk, 0);
      cur_restart = was_idle;
      was_idle = 0; frame_full = 1; bitpos = 0; slot_i = 0;
      adc_q.delete();
      adc_q.push_back(prev_adc);
      dac_exp.delete();
      cur_frame = (dac_pending.size() > 0) ? dac_pending.pop_front() : 32'h0;
      dac_exp.push_back(cur_frame);
      sdin = cur_frame[31];
    end else if (fell && !idle) begin
      slot_i++;
      sdin = (slot_i < 32) ? cur_frame[31 - slot_i] : 1'b0;
    end
    if (brise && !idle) begin
      if (have_rise)
        check(since_rise == (eff_ratio ? 8 : 16), "R1", "bclk period",
              since_rise, eff_ratio ? 8 : 16);
      have_rise = 1; since_rise = 0;
      check(fclk == (bitpos < 16), "R2", "fclk level at slot", fclk, bitpos < 16);
      if (bitpos < 16) begin
        acc = {acc[14:0], sdout};
        if (bitpos == 15 && adc_q.size() > 0) begin
          logic [15:0] e;
          e = adc_q.pop_front();
          check(acc == e, cur_restart ? "R10" : "R3", "ADC word (R9 capture)", acc, e);
          adc_done++;
        end
      end else begin
        check(sdout == 1'b0, "R4", "sdout in low half", sdout, 0);
      end
      bitpos++;
    end
    if (dac_valid) begin
      if (dac_exp.size() > 0) begin
        logic [31:0] e;
        e = dac_exp.pop_front();
        check({dac_left, dac_right} == e, "R6", "DAC pair", {dac_left, dac_right}, e);
        dac_done++;
      end else begin
        check(0, "R6", "unexpected valid", 1, 0);
      end
    end
    prev_b = bclk; prev_l = fclk; prev_s = sdout; prev_adc = adc_word;
  end

  // mid-frame churn of the parallel ADC input
  initial begin
    int n = 0;
    while (!done) begin
      repeat (53) @(posedge clk);
      #2;
      n++;
      case (n % 6)
        0: adc_word = 16'h7FFF;
        1: adc_word = 16'hFFFF;
        2: adc_word = 16'h0000;
        default: adc_word = {adc_word[14:0], adc_word[15] ^ adc_word[13] ^ adc_word[12] ^ adc_word[10]} ^ 16'h0101;
      endcase
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        check(0, "R1", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    cycles(5);
    @(negedge clk);
    check(dac_valid == 0 && dac_left == 0 && dac_right == 0, "R10", "reset outputs",
          {dac_valid, dac_left, dac_right}, 0);
    check(!bclk && !fclk && !sdout, "R10", "reset serial pins", {bclk, fclk, sdout}, 0);
    cycles(1);
    rst = 0;
    push_dac(16'h8000, 16'h7FFF);
    push_dac(16'hFFFF, 16'h0000);
    push_dac(16'h1234, 16'hABCD);
    push_dac(16'h0001, 16'h8001);
    push_dac(16'hA5A5, 16'h5A5A);
    pd_adc = 0;
    cycles(4 * 256 + 20);
    ratio_sel = 0;                       // R8: no effect while running
    cycles(2 * 256);
    pd_adc = 1;
    cycles(20);                          // R7 parked, R8 latch 512fs
    check(dac_done >= 5, "R6", "pairs received at 256fs", dac_done, 5);
    push_dac(16'hC001, 16'h3FFE);
    push_dac(16'h8000, 16'hFFFF);
    push_dac(16'h7FFF, 16'h0001);
    pd_dac_l = 0;
    cycles(4 * 512 + 20);
    cycles(300);
    pd_dac_l = 1;                        // abort mid-frame
    cycles(10);
    push_dac(16'h0F0F, 16'hF0F0);
    push_dac(16'h4321, 16'h8765);
    pd_dac_r = 0;
    cycles(3 * 512 + 200);
    rst = 1;                             // R10 reset mid-frame
    cycles(5);
    rst = 0;
    push_dac(16'hDEAD, 16'hBEEF);
    cycles(3 * 256 + 20);
    pd_dac_r = 1;
    cycles(20);
    check(adc_done >= 15, "R3", "ADC words seen", adc_done, 15);
    check(dac_done >= 14, "R6", "DAC pairs seen", dac_done, 14);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule